// File: doc/BRIEF.md
# Fast-path Ethernet frame classifier

This block watches a received Ethernet frame as it arrives, one 32-bit word per accepted beat. It then sorts the frame into one of three classes. A streaming data frame goes to the fast path. A frame that assigns a new IPv4 address is a recovery frame. Every other frame goes to the slow path, which forwards it to a processor.

Each frame starts with two pad bytes in front of the 14-byte MAC header. Word boundaries therefore follow the pad, and bytes are packed big-endian, with the first byte in bits 31:24. The classifier checks only a few fixed word positions. It never buffers the frame.

The result is a one-hot verdict that lasts one cycle. For a recovery frame, the block also captures the address word and pulses a valid strobe. For a slow-path frame, it reports the frame length in words as a line count.

Top module: `fp_frame_classifier`

## Requirements
- R1: A frame is fast-path (verdict 3'b001) when two conditions hold: bits 15:0 of word index 9 equal `cfg_data_port`, and word index 12 differs from `cfg_invalid_hdr`.
- R2: A frame whose word 9 port matches but whose word 12 equals `cfg_invalid_hdr` is not fast-path.
- R3: A frame whose end word has an index below 12 is never fast-path.
- R4: A frame is a recovery frame (verdict 3'b010) when all of the following hold: it is not fast-path, bits 15:0 of word 3 equal 16'hBEEE, word 4 equals 32'h61646472 (the text "addr"), and word 5 has arrived. In that case `addr_out` takes the value of word 5 and `addr_valid` is high in the verdict cycle.
- R5: The fast-path test has priority. A frame that passes both tests gets verdict 3'b001, `addr_valid` stays low, and `addr_out` keeps its previous value.
- R6: Every other frame gets verdict 3'b100. Its `slow_len` equals the index of its end word minus 3, floored at 0.
- R7: The verdict is exactly one-hot for a single cycle: the cycle after the accepted end word. At all other times it is 3'b000.
- R8: Reset clears the verdict, `addr_valid`, `addr_out`, `slow_len` and any partly received frame.
- R9: Several kinds of beat are ignored: beats with `in_valid` low, and valid beats that arrive outside a frame (that is, before any `in_sof`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Beat qualifier |
| in_sof | input | 1 | First word of a frame (index 0) |
| in_eof | input | 1 | Last word of a frame |
| in_data | input | 32 | Frame word, big-endian bytes |
| cfg_data_port | input | 16 | UDP port of streaming data |
| cfg_invalid_hdr | input | 32 | Stream header value that disqualifies fast path |
| verdict | output | 3 | One-hot result: bit0 fast, bit1 recovery, bit2 slow |
| addr_out | output | 32 | Last captured recovery address |
| addr_valid | output | 1 | Pulse when addr_out was just updated |
| slow_len | output | 12 | Slow-path length: end index minus 3 |

## Verification
The hardest cases to reach are frames that end exactly around the significant word positions. Examples are a frame that stops at word 11 or 12 while carrying a matching port, and a recovery frame cut off before its address word. To reach them, the bench sweeps every frame length from 1 to 16 words across sixteen header combinations. Some of these combinations set both the fast-path fields and the recovery fields.

Odd lengths insert idle beats between words, and those idle beats carry stray start and end markers. Valid end-marked words are also sent between frames.

// File: rtl/fp_frame_classifier.sv
module fp_frame_classifier #(
  parameter int          IDX_W       = 12,
  parameter int          PORT_WORD   = 9,
  parameter int          HDR_WORD    = 12,
  parameter int          ETYPE_WORD  = 3,
  parameter int          CODE_WORD   = 4,
  parameter int          ADDR_WORD   = 5,
  parameter int          LEN_ADJ     = 3,
  parameter logic [15:0] RECOV_ETYPE = 16'hBEEE,
  parameter logic [31:0] RECOV_CODE  = 32'h61646472
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [31:0]      in_data,
  input  logic [15:0]      cfg_data_port,
  input  logic [31:0]      cfg_invalid_hdr,
  output logic [2:0]       verdict,
  output logic [31:0]      addr_out,
  output logic             addr_valid,
  output logic [IDX_W-1:0] slow_len
);
  localparam logic [IDX_W-1:0] IDX_MAX = '1;
  localparam logic [IDX_W-1:0] ADJ     = IDX_W'(LEN_ADJ);

  logic             in_frame;
  logic [IDX_W-1:0] idx;
  logic             port_hit, hdr_hit, etype_hit, code_hit, addr_seen;
  logic [31:0]      addr_hold;

  wire              take = in_valid && (in_sof || in_frame);
  wire [IDX_W-1:0]  cur  = in_sof ? '0 : idx;
  wire              keep = !in_sof;

  wire nxt_port  = (port_hit  && keep) || (cur == IDX_W'(PORT_WORD)  && in_data[15:0] == cfg_data_port);
  wire nxt_hdr   = (hdr_hit   && keep) || (cur == IDX_W'(HDR_WORD)   && in_data != cfg_invalid_hdr);
  wire nxt_etype = (etype_hit && keep) || (cur == IDX_W'(ETYPE_WORD) && in_data[15:0] == RECOV_ETYPE);
  wire nxt_code  = (code_hit  && keep) || (cur == IDX_W'(CODE_WORD)  && in_data == RECOV_CODE);
  wire nxt_addr_seen = (addr_seen && keep) || (cur == IDX_W'(ADDR_WORD));
  wire [31:0] nxt_addr = (cur == IDX_W'(ADDR_WORD)) ? in_data : addr_hold;

  wire is_fast = nxt_port && nxt_hdr;
  wire is_rec  = !is_fast && nxt_etype && nxt_code && nxt_addr_seen;
  wire [IDX_W-1:0] len_now = (cur >= ADJ) ? cur - ADJ : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_frame   <= 1'b0;
      idx        <= '0;
      port_hit   <= 1'b0;
      hdr_hit    <= 1'b0;
      etype_hit  <= 1'b0;
      code_hit   <= 1'b0;
      addr_seen  <= 1'b0;
      addr_hold  <= '0;
      verdict    <= '0;
      addr_out   <= '0;
      addr_valid <= 1'b0;
      slow_len   <= '0;
    end else begin
      verdict    <= '0;
      addr_valid <= 1'b0;
      if (take) begin
        idx       <= (cur == IDX_MAX) ? cur : cur + 1'b1;
        in_frame  <= !in_eof;
        port_hit  <= nxt_port;
        hdr_hit   <= nxt_hdr;
        etype_hit <= nxt_etype;
        code_hit  <= nxt_code;
        addr_seen <= nxt_addr_seen;
        addr_hold <= nxt_addr;
        if (in_eof) begin
          if (is_fast) begin
            verdict <= 3'b001;
          end else if (is_rec) begin
            verdict    <= 3'b010;
            addr_out   <= nxt_addr;
            addr_valid <= 1'b1;
          end else begin
            verdict  <= 3'b100;
            slow_len <= len_now;
          end
        end
      end
    end
  end

  // R7
  verdict_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(verdict));

  // R7
  verdict_after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (verdict != 3'b000) |-> $past(in_valid && in_eof));

  // R4
  addr_strobe_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (verdict == 3'b010));

  // R5
  fast_keeps_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict[0] |-> $stable(addr_out));

  // R6
  slow_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    verdict[2] |-> !addr_valid && $stable(addr_out));
endmodule

// File: tb/tb_fp_frame_classifier.sv
module tb_fp_frame_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [31:0] in_data = '0;
  logic [15:0] cfg_data_port = 16'h1234;
  logic [31:0] cfg_invalid_hdr = 32'hDEAD0000;
  logic [2:0]  verdict;
  logic [31:0] addr_out;
  logic        addr_valid;
  logic [11:0] slow_len;

  fp_frame_classifier dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .cfg_data_port(cfg_data_port), .cfg_invalid_hdr(cfg_invalid_hdr),
    .verdict(verdict), .addr_out(addr_out), .addr_valid(addr_valid), .slow_len(slow_len)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_total = 0, n_fail = 0, cycles = 0;
  logic [31:0] fw [0:31];
  logic [31:0] exp_addr = '0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_total++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
      summary();
    end
  end

  task automatic build(input int kind, input int seq);
    for (int i = 0; i < 32; i++) fw[i] = {8'(i), 8'hA5, 16'(i * 3)};
    if (kind[0]) fw[9][15:0] = cfg_data_port;
    if (kind[1]) fw[12] = cfg_invalid_hdr;
    if (kind[2]) begin
      fw[3][15:0] = 16'hBEEE;
      fw[4] = kind[3] ? 32'h61646473 : 32'h61646472;
    end
    fw[5] = 32'h0A000000 + 32'(seq);
  endtask

  task automatic send(input int len, input bit gap);
    bit mid_bad = 0;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      if (verdict != 3'b000) mid_bad = 1;
      in_valid = 1'b1; in_sof = (i == 0); in_eof = (i == len - 1); in_data = fw[i];
      if (gap && i < len - 1) begin
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b1; in_eof = 1'b1; in_data = 32'hFFFFFFFF;
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    chk(!mid_bad, "R7 no verdict mid-frame", 32'(mid_bad), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(verdict == 3'b000 && !addr_valid && addr_out == 0 && slow_len == 0,
        "R8 reset state", {verdict, addr_valid, addr_out[27:0]}, 0);
    rst_n = 1'b1;

    for (int cfg = 0; cfg < 2; cfg++) begin
      cfg_data_port   = cfg ? 16'hC0DE : 16'h1234;
      cfg_invalid_hdr = cfg ? 32'h00000000 : 32'hDEAD0000;
      for (int len = 1; len <= 16; len++) begin
        for (int kind = 0; kind < 16; kind++) begin
          bit fast, rec;
          logic [2:0] ev;
          int el;
          build(kind, cfg * 1000 + len * 16 + kind);
          fast = kind[0] && !kind[1] && len >= 13;
          rec  = !fast && kind[2] && !kind[3] && len >= 6;
          ev = fast ? 3'b001 : (rec ? 3'b010 : 3'b100);
          el = (len >= 4) ? len - 4 : 0;
          send(len, len[0]);
          if (rec) exp_addr = fw[5];
          // R1 R2 R3 R4 R5 R6: verdict class
          chk(verdict == ev, $sformatf("R1/R2/R3/R4/R5/R6 verdict len=%0d kind=%0d", len, kind),
              32'(verdict), 32'(ev));
          chk(addr_valid == rec, "R4 addr_valid strobe", 32'(addr_valid), 32'(rec));
          chk(addr_out == exp_addr, "R5 addr_out value", addr_out, exp_addr);
          if (ev == 3'b100)
            chk(slow_len == 12'(el), "R6 slow_len", 32'(slow_len), 32'(el));
          @(negedge clk);
          chk(verdict == 3'b000 && !addr_valid, "R7 single cycle verdict", 32'(verdict), 0);
        end
      end
    end

    // R9: valid end-marked words outside any frame are ignored
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sof = 1'b0; in_eof = 1'b1; in_data = 32'h0;
    end
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
    chk(verdict == 3'b000, "R9 stray words ignored", 32'(verdict), 0);
    @(negedge clk);
    chk(verdict == 3'b000, "R9 stray words ignored later", 32'(verdict), 0);

    // R8: reset mid-frame clears state and addr_out
    build(4, 77);
    send(8, 1'b0);
    chk(addr_out == 32'h0A00004D, "R4 captured before reset", addr_out, 32'h0A00004D);
    @(negedge clk);
    in_valid = 1'b1; in_sof = 1'b1; in_data = 32'h0;
    @(negedge clk);
    in_sof = 1'b0; rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(addr_out == 0 && verdict == 0 && slow_len == 0, "R8 reset clears", addr_out, 0);
    rst_n = 1'b1;
    @(negedge clk);
    in_valid = 1'b1; in_eof = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_eof = 1'b0;
    chk(verdict == 3'b000, "R8 partial frame dropped by reset", 32'(verdict), 0);
    summary();
  end
endmodule